// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block is a behavioural model of a synchronous burst static RAM with flow-through reads. The array has two 9-bit byte lanes. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input and three kinds of write enable. From these it picks one of three addresses: the external address, the next burst address, or the address already held. It then performs a read, a write with byte masking, a deselect or a burst suspend.

Read data comes out combinationally from the registered address, in the same cycle as the edge that set up the access. The data bus is split into a data output, a data input and a drive-enable. An asynchronous output enable and a sleep input gate the drive-enable. The array depth is a parameter. The default is small so that the model stays light; a deployment sets it to 17 address bits.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A cycle is a write when `global_wr_ni` is 0, and then both lanes are written. It is also a write when `lane_wr_en_ni` is 0 and at least one bit of `lane_wr_ni` is 0. In that case only the lanes whose bit is 0 are written (bit 0 = data bits 8:0, bit 1 = data bits 17:9). Every other combination is a read.
- R2: A clock with `proc_strobe_ni` at 0 and the chip selected always starts a read at `addr_i`, whatever the write inputs are. The stored word appears on `dq_o` during the cycle that follows that edge.
- R3: A write starts only on a clock with `ctrl_strobe_ni` at 0 and `proc_strobe_ni` at 1, using `addr_i`, or on a later burst clock with no strobe. `dq_i` is captured at that same edge.
- R4: A clock with either strobe at 0 deselects the device when `sel_a_ni` is 1, `sel_b_i` is 0 or `sel_c_ni` is 1. The bus is then not driven. Clocks with no strobe that follow neither read nor write until a new access is selected.
- R5: On a clock with no strobe and `burst_adv_ni` at 0, an active burst moves to the next address. The two low address bits count up by one and wrap from 3 to 0 within the 4-word block; the upper bits are unchanged.
- R6: On a clock with no strobe and `burst_adv_ni` at 1, an active burst is suspended and reuses its current address, for both reads and writes.
- R7: `out_en_ni` acts combinationally and is not sampled. During a read, `dq_oe_o` is 1 exactly while `out_en_ni` is 0, and changes within the cycle when `out_en_ni` toggles.
- R8: During a write cycle `dq_oe_o` stays 0 whatever the value of `out_en_ni`.
- R9: While `sleep_i` is 1 the bus is not driven and no access is taken. After `sleep_i` returns to 0, the first two clock edges are ignored and the third edge accepts an access.
- R10: After reset, `dq_oe_o` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| sel_a_ni | input | 1 | Chip select A, active low |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, always a read |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| burst_adv_ni | input | 1 | Burst advance, active low; high suspends |
| global_wr_ni | input | 1 | Write all lanes, active low |
| lane_wr_en_ni | input | 1 | Enables per-lane writes, active low |
| lane_wr_ni | input | LANES | Per-lane write enables, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench drives a processor-strobe read with the global write input low. A model that honoured that write input would store data and stop driving the bus when it should be reading. Bursts are run across the 3-to-0 wrap and through suspends: a counter that carries into the upper bits, or that advances while suspended, returns the wrong word. Deselects are followed by burst clocks that try to write, and a later read-back catches any write that leaked through. Sleep is released and accesses are attempted on each of the first three edges, so a recovery window that is too short or too long shows up on the drive-enable. Output enable is toggled in the middle of a read, and left low during writes, to catch a version that registers it or fails to mask it.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef struct packed {
    logic load_ext;
    logic step;
    logic hold;
    logic do_read;
    logic do_write;
    logic go_idle;
  } sram_op_t;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             proc_strobe_ni,
  input  logic             ctrl_strobe_ni,
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             burst_adv_ni,
  input  logic             global_wr_ni,
  input  logic             lane_wr_en_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic             active_i,
  input  logic             accept_i,
  output sram_op_t         op_o,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] wr_mask;
  logic             is_wr, new_acc, desel;

  always_comb begin
    if (!global_wr_ni)       wr_mask = '1;
    else if (!lane_wr_en_ni) wr_mask = ~lane_wr_ni;
    else                     wr_mask = '0;
  end

  assign is_wr   = |wr_mask;
  assign new_acc = !proc_strobe_ni || !ctrl_strobe_ni;
  assign desel   = sel_a_ni || !sel_b_i || sel_c_ni;

  always_comb begin
    op_o = '0;
    if (!accept_i) begin
      op_o.go_idle = 1'b1;
    end else if (new_acc) begin
      if (desel) begin
        op_o.go_idle = 1'b1;
      end else begin
        op_o.load_ext = 1'b1;
        // processor strobe wins and forces a read
        if (!proc_strobe_ni || !is_wr) op_o.do_read  = 1'b1;
        else                           op_o.do_write = 1'b1;
      end
    end else if (active_i) begin
      if (burst_adv_ni) op_o.hold = 1'b1;
      else              op_o.step = 1'b1;
      if (is_wr) op_o.do_write = 1'b1;
      else       op_o.do_read  = 1'b1;
    end
  end

  assign lane_we_o = op_o.do_write ? wr_mask : '0;

  p_proc_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !proc_strobe_ni |-> lane_we_o == '0);
  p_write_lanes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we_o != '0 && global_wr_ni) |-> !lane_wr_en_ni);
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  logic [ADDR_W-1:0]  addr_q, next_addr;
  logic [BURST_W-1:0] low_inc;

  assign low_inc   = addr_q[BURST_W-1:0] + BURST_W'(1);
  assign next_addr = {addr_q[ADDR_W-1:BURST_W], low_inc};

  always_comb begin
    if (load_i)      eff_addr_o = ext_addr_i;
    else if (step_i) eff_addr_o = next_addr;
    else             eff_addr_o = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= eff_addr_o;
  end

  assign addr_q_o = addr_q;

  p_burst_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1))
      && (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])));
  p_suspend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_q));
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl #(
  parameter int REC_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic accept_o
);
  localparam int CW = $clog2(REC_CYC + 1);
  logic [CW-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rec_q <= '0;
    else if (sleep_i)      rec_q <= CW'(REC_CYC);
    else if (rec_q != '0)  rec_q <= rec_q - CW'(1);
  end

  assign accept_o = !sleep_i && (rec_q == '0);

  p_rec_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_q <= CW'(REC_CYC));
  p_wake_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> !accept_o);
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int REC_CYC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    proc_strobe_ni,
  input  logic                    ctrl_strobe_ni,
  input  logic                    burst_adv_ni,
  input  logic                    global_wr_ni,
  input  logic                    lane_wr_en_ni,
  input  logic [LANES-1:0]        lane_wr_ni,
  input  logic                    out_en_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  sram_op_t          op;
  logic [LANES-1:0]  lane_we;
  logic              accept, active_q, rd_q;
  logic [ADDR_W-1:0] eff_addr, addr_q;

  sram_sleep_ctrl #(.REC_CYC(REC_CYC)) u_sleep (
    .clk_i, .rst_ni, .sleep_i, .accept_o(accept)
  );

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .clk_i, .rst_ni, .proc_strobe_ni, .ctrl_strobe_ni,
    .sel_a_ni, .sel_b_i, .sel_c_ni, .burst_adv_ni,
    .global_wr_ni, .lane_wr_en_ni, .lane_wr_ni,
    .active_i(active_q), .accept_i(accept),
    .op_o(op), .lane_we_o(lane_we)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .load_i(op.load_ext), .step_i(op.step),
    .ext_addr_i(addr_i), .eff_addr_o(eff_addr), .addr_q_o(addr_q)
  );

  sram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i, .we_i(lane_we), .waddr_i(eff_addr), .wdata_i(dq_i),
    .raddr_i(addr_q), .rdata_o(dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (op.go_idle) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (op.load_ext || op.step || op.hold) begin
      active_q <= 1'b1;
      rd_q     <= op.do_read;
    end
  end

  // output enable is asynchronous: no register on this path
  assign dq_oe_o = active_q && rd_q && !out_en_ni && !sleep_i;

  p_oe_write_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !rd_q) |-> !dq_oe_o);
  p_sleep_tristate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);
  p_desel_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!proc_strobe_ni || !ctrl_strobe_ni) && (sel_a_ni || !sel_b_i || sel_c_ni))
      |=> !active_q);
  p_proc_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && accept && !sel_a_ni && sel_b_i && !sel_c_ni)
      |=> (active_q && rd_q));
  p_sleep_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active_q);
endmodule

// File: tb/sim_burst_sram_ctrl.sv
`timescale 1ns/1ps
module sim_burst_sram_ctrl;
  localparam int AW = 8;
  localparam int DW = 18;

  typedef struct {
    logic          oe;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic clk_i = 0, rst_ni = 0;
  logic [AW-1:0] addr_i = '0;
  logic sel_a_ni = 0, sel_b_i = 1, sel_c_ni = 0;
  logic proc_strobe_ni = 1, ctrl_strobe_ni = 1, burst_adv_ni = 1;
  logic global_wr_ni = 1, lane_wr_en_ni = 1;
  logic [1:0] lane_wr_ni = 2'b11;
  logic out_en_ni = 0, sleep_i = 0;
  logic [DW-1:0] dq_i = '0, dq_o;
  logic dq_oe_o;

  int checks = 0, errors = 0;
  exp_t exp_q[$];

  logic [DW-1:0] ref_mem [1<<AW];
  bit m_act, m_rd;
  logic [AW-1:0] m_addr;
  int m_rec;

  always #5 clk_i = ~clk_i;

  burst_sram_ctrl u0 (.*);

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // reference model step, evaluated with the inputs driven for this cycle
  task automatic tick(string tag);
    bit acc, newa, desel, wr;
    logic [1:0] msk;
    logic [AW-1:0] ea;
    exp_t e;
    acc = !sleep_i && m_rec == 0;
    if (sleep_i) m_rec = 2; else if (m_rec > 0) m_rec--;
    msk = !global_wr_ni ? 2'b11 : (!lane_wr_en_ni ? ~lane_wr_ni : 2'b00);
    wr = msk != 0;
    newa = !proc_strobe_ni || !ctrl_strobe_ni;
    desel = sel_a_ni || !sel_b_i || sel_c_ni;
    ea = m_addr;
    if (!acc) begin m_act = 0; m_rd = 0; msk = 0; end
    else if (newa) begin
      if (desel) begin m_act = 0; m_rd = 0; msk = 0; end
      else begin
        ea = addr_i; m_act = 1;
        if (!proc_strobe_ni || !wr) begin m_rd = 1; msk = 0; end else m_rd = 0;
      end
    end else if (m_act) begin
      if (!burst_adv_ni) ea = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      m_rd = !wr;
    end else msk = 0;
    if (msk[0]) ref_mem[ea][8:0]  = dq_i[8:0];
    if (msk[1]) ref_mem[ea][17:9] = dq_i[17:9];
    m_addr = ea;
    e.oe = m_act && m_rd && !out_en_ni && !sleep_i;
    e.data = ref_mem[m_addr];
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic drv(bit p, bit c, bit adv, bit gw, bit be, logic [1:0] bw,
                     logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    proc_strobe_ni = p; ctrl_strobe_ni = c; burst_adv_ni = adv;
    global_wr_ni = gw; lane_wr_en_ni = be; lane_wr_ni = bw;
    addr_i = a; dq_i = d;
    tick(tag);
  endtask

  task automatic idle(string tag);
    drv(1, 1, 1, 1, 1, 2'b11, '0, '0, tag);
  endtask

  // monitor: compare one expected item per clock
  initial begin
    exp_t it;
    forever begin
      @(posedge clk_i); #2;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(dq_oe_o === it.oe, it.tag, "drive", DW'(dq_oe_o), DW'(it.oe));
        if (it.oe) chk(dq_o === it.data, it.tag, "data", dq_o, it.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = 'x;
    m_act = 0; m_rd = 0; m_addr = '0; m_rec = 0;
    #12;
    chk(dq_oe_o === 1'b0, "R10", "reset drive", DW'(dq_oe_o), '0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    idle("R10");

    // R3 R1: controller-strobe writes, global write fills both lanes
    for (int i = 0; i < 4; i++) drv(1, 0, 1, 0, 1, 2'b11, AW'(8'h10 + i), DW'(18'h1000 + i*18'h111), "R3");
    for (int i = 0; i < 4; i++) drv(1, 0, 1, 0, 1, 2'b11, AW'(8'h20 + i), DW'(18'h2A5A5 + i), "R3");
    // R1: per-lane write at 0x11 lane 0 only
    drv(1, 0, 1, 1, 0, 2'b10, 8'h11, 18'h3FFFF, "R1");
    // R1: lane enable high -> read, no write
    drv(1, 0, 1, 1, 1, 2'b00, 8'h12, 18'h00000, "R1");

    // R2: processor strobe with write inputs low still reads
    drv(0, 1, 1, 0, 0, 2'b00, 8'h12, 18'h15555, "R2");
    // R5: continue 0x13 then wrap to 0x10
    drv(1, 1, 0, 1, 1, 2'b11, '0, '0, "R5");
    drv(1, 1, 0, 1, 1, 2'b11, '0, '0, "R5");
    // R6: suspend holds 0x10
    drv(1, 1, 1, 1, 1, 2'b11, '0, '0, "R6");
    drv(1, 1, 0, 1, 1, 2'b11, '0, '0, "R5");

    // R7: output enable toggled mid-cycle
    out_en_ni = 1; #1;
    chk(dq_oe_o === 1'b0, "R7", "oe high", DW'(dq_oe_o), '0);
    out_en_ni = 0; #1;
    chk(dq_oe_o === 1'b1, "R7", "oe low", DW'(dq_oe_o), DW'(1));
    chk(dq_o === ref_mem[8'h11], "R7", "data", dq_o, ref_mem[8'h11]);
    @(negedge clk_i);
    out_en_ni = 1; drv(1, 1, 1, 1, 1, 2'b11, '0, '0, "R7");
    out_en_ni = 0;

    // R3 R8: processor read, then burst write into lane 1 with oe low
    drv(0, 1, 1, 1, 1, 2'b11, 8'h20, '0, "R3");
    drv(1, 1, 0, 1, 0, 2'b01, '0, 18'h3FE00, "R8");
    drv(1, 1, 1, 0, 1, 2'b11, '0, 18'h0ABCD, "R8");
    drv(0, 1, 0, 1, 1, 2'b11, 8'h21, '0, "R3");
    drv(1, 1, 0, 1, 1, 2'b11, '0, '0, "R5");

    // R4: deselect by each select, then burst writes must be ignored
    sel_b_i = 0; drv(1, 0, 1, 0, 1, 2'b11, 8'h10, 18'h3FFFF, "R4");
    sel_b_i = 1; drv(1, 1, 0, 0, 1, 2'b11, '0, 18'h3FFFF, "R4");
    sel_a_ni = 1; drv(0, 1, 1, 1, 1, 2'b11, 8'h10, '0, "R4");
    sel_a_ni = 0; sel_c_ni = 1; drv(1, 0, 1, 1, 1, 2'b11, 8'h10, '0, "R4");
    sel_c_ni = 0; drv(1, 1, 1, 0, 1, 2'b11, '0, 18'h3FFFF, "R4");
    for (int i = 0; i < 4; i++)
      drv(i == 0 ? 1'b0 : 1'b1, 1, i == 0 ? 1'b1 : 1'b0, 1, 1, 2'b11, 8'h10, '0, "R4");

    // R9: sleep mid-read, then recovery window
    drv(0, 1, 1, 1, 1, 2'b11, 8'h22, '0, "R9");
    sleep_i = 1; #1;
    chk(dq_oe_o === 1'b0, "R9", "sleep drive", DW'(dq_oe_o), '0);
    drv(0, 1, 1, 1, 1, 2'b11, 8'h22, '0, "R9");
    drv(0, 1, 1, 1, 1, 2'b11, 8'h22, '0, "R9");
    sleep_i = 0;
    drv(0, 1, 1, 1, 1, 2'b11, 8'h23, '0, "R9");
    drv(0, 1, 1, 1, 1, 2'b11, 8'h23, '0, "R9");
    drv(0, 1, 1, 1, 1, 2'b11, 8'h23, '0, "R9");
    drv(1, 1, 0, 1, 1, 2'b11, '0, '0, "R5");
    idle("R6");
    idle("R6");

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule